// File: doc/BRIEF.md
# Programmable Display Data-Enable Generator

This block produces the data-enable strobe that a flat panel needs to know which pixels of a digitized video stream are visible. It runs on the pixel clock and takes the horizontal and vertical sync signals of the stream. A pixel counter restarts at every horizontal sync and advances on every pixel clock. A line counter restarts at every vertical sync and advances on every horizontal sync. Data enable is high only while both counters are inside their programmed windows. It is held low for as long as vertical sync is asserted.

Software sets four values through a small write port: the horizontal start, the horizontal length, the vertical start and the vertical length. One design therefore serves any display mode whose native size fits the counters. Writes are accepted at any time. They are held in a pending bank and move into the live bank only at the next assertion of vertical sync, so a frame never shows a mix of old and new settings. Each sync input has its own polarity select. Both syncs pass through a synchronizer and an edge detector, so all counting is plain synchronous logic.

Top module: `de_window_gen`

## Requirements
- R1: While reset is asserted and after it is released, `de_out` is low. The live window starts at its default values: horizontal start 148, horizontal length 512, vertical start 26, vertical length 768.
- R2: The pixel counter clears on the asserting edge of horizontal sync and advances by one per clock. With a horizontal start S, the first high cycle of `de_out` in a line is sampled on the (S+5)th rising clock edge. Edge 1 is the first rising edge after the sync input asserts. The delay comes from two synchronizer stages, the edge register, the counter and the output register.
- R3: In every active line, `de_out` is high for exactly L consecutive clock cycles, where L is the horizontal length. These are the pixel counts S+1 through S+L.
- R4: The line counter clears to 0 on the asserting edge of vertical sync, which takes priority over a horizontal edge in the same cycle. It advances by one on each asserting edge of horizontal sync. Only lines whose count lies in VS+1 through VS+VL carry `de_out`, where VS is the vertical start and VL is the vertical length.
- R5: `de_out` is low in every line during which the synchronized vertical sync is asserted, even when that line lies inside the vertical window.
- R6: A polarity input of 1 makes the high level of its sync asserted. A polarity input of 0 makes the low level asserted. Both give identical `de_out` timing.
- R7: A write with `cfg_wr_en` high stores `cfg_wr_data` into the pending register chosen by `cfg_wr_addr`. Address 0 is horizontal start, 1 is horizontal length, 2 is vertical start and 3 is vertical length.
- R8: Pending values move into the live window only on the asserting edge of vertical sync. Writes made in the middle of a frame leave the rest of that frame unchanged, and the next frame uses the new values.
- R9: Both counters saturate at 2^CNT_W-1 and never wrap. When horizontal sync stops arriving, `de_out` stays low as long as start plus length is below that maximum.
- R10: A horizontal length or vertical length of 0 keeps `de_out` low for every pixel or every line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_in | input | 1 | Horizontal sync from the video stream |
| vsync_in | input | 1 | Vertical sync from the video stream |
| hsync_act_high | input | 1 | 1: horizontal sync asserted high; 0: asserted low |
| vsync_act_high | input | 1 | 1: vertical sync asserted high; 0: asserted low |
| cfg_wr_en | input | 1 | Write strobe for the window registers |
| cfg_wr_addr | input | 2 | Register select (0 h-start, 1 h-length, 2 v-start, 3 v-length) |
| cfg_wr_data | input | CNT_W | Value to write |
| de_out | output | 1 | Registered data-enable strobe |

## Verification
The bound checker watches several rules on every cycle. A sync edge clears its counter, and the pixel counter steps by exactly one between edges. Both counters hold at their maximum. The line counter changes only on sync edges. The live window changes only on a vertical edge. Data enable is low in the cycle after vertical sync is seen asserted. The exact placement and width of the window can only be shown by the bench's frames, because they depend on the programmed values and on the pipeline latency. The same applies to the deferred effect of mid-frame writes, to either sync polarity, to zero lengths, to the default window after reset, and to a long gap with no horizontal sync.

// File: rtl/degen_pkg.sv
package degen_pkg;

    // Register select codes of the configuration write port
    typedef enum logic [1:0] {
        CFG_PIX_START  = 2'd0,
        CFG_PIX_LEN    = 2'd1,
        CFG_LINE_START = 2'd2,
        CFG_LINE_LEN   = 2'd3
    } cfg_addr_e;

    localparam int unsigned NUM_CFG  = 4;
    localparam int unsigned NUM_AXIS = 2;
    localparam int unsigned AXIS_H   = 0;
    localparam int unsigned AXIS_V   = 1;

endpackage

// File: rtl/degen_sync_edge.sv
module degen_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    input  logic act_high,
    output logic level_o,
    output logic start_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_state_t;

    sync_state_t s_d, s_q;
    logic [STAGES:0] shift_ext;
    logic            lvl;

    always_comb begin
        s_d       = s_q;
        shift_ext = {s_q.chain, raw_in};
        s_d.chain = shift_ext[STAGES-1:0];
        lvl       = act_high ? s_q.chain[STAGES-1] : ~s_q.chain[STAGES-1];
        s_d.prev  = lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.chain <= '0;
            s_q.prev  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign level_o = lvl;
    assign start_o = lvl & ~s_q.prev;

endmodule

// File: rtl/degen_sat_counter.sv
module degen_sat_counter #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count_o
);

    localparam logic [W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (clr) begin
            c_d.cnt = '0;
        end else if (inc && (c_q.cnt != CNT_MAX)) begin
            c_d.cnt = c_q.cnt + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q.cnt <= CNT_MAX;
        end else begin
            c_q <= c_d;
        end
    end

    assign count_o = c_q.cnt;

endmodule

// File: rtl/degen_cfg_bank.sv
module degen_cfg_bank
    import degen_pkg::*;
#(
    parameter int unsigned  W          = 12,
    parameter logic [W-1:0] DEF_HSTART = 148,
    parameter logic [W-1:0] DEF_HLEN   = 512,
    parameter logic [W-1:0] DEF_VSTART = 26,
    parameter logic [W-1:0] DEF_VLEN   = 768
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [1:0]                wr_addr,
    input  logic [W-1:0]              wr_data,
    input  logic                      commit,
    output logic [NUM_CFG-1:0][W-1:0] live_o
);

    localparam logic [NUM_CFG-1:0][W-1:0] DEFAULTS =
        {DEF_VLEN, DEF_VSTART, DEF_HLEN, DEF_HSTART};

    typedef struct packed {
        logic [NUM_CFG-1:0][W-1:0] pend;
        logic [NUM_CFG-1:0][W-1:0] live;
    } bank_state_t;

    bank_state_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        // a write in the commit cycle is kept for the following frame
        if (commit) begin
            b_d.live = b_q.pend;
        end
        if (wr_en) begin
            b_d.pend[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_q.pend <= DEFAULTS;
            b_q.live <= DEFAULTS;
        end else begin
            b_q <= b_d;
        end
    end

    assign live_o = b_q.live;

endmodule

// File: rtl/degen_window.sv
module degen_window #(
    parameter int unsigned W = 12
) (
    input  logic [W-1:0] count,
    input  logic [W-1:0] first,
    input  logic [W-1:0] len,
    output logic         inside_o
);

    // exclusive upper bound first+len+1 needs one extra bit
    logic [W:0] limit;

    always_comb begin
        limit    = {1'b0, first} + {1'b0, len} + (W+1)'(1);
        inside_o = (count > first) && ({1'b0, count} < limit);
    end

endmodule

// File: rtl/de_window_gen.sv
module de_window_gen
    import degen_pkg::*;
#(
    parameter int unsigned      CNT_W          = 12,
    parameter int unsigned      SYNC_STAGES    = 2,
    parameter logic [CNT_W-1:0] DEF_PIX_START  = 12'h094,
    parameter logic [CNT_W-1:0] DEF_PIX_LEN    = 12'h200,
    parameter logic [CNT_W-1:0] DEF_LINE_START = 12'h01A,
    parameter logic [CNT_W-1:0] DEF_LINE_LEN   = 12'h300
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsync_in,
    input  logic             vsync_in,
    input  logic             hsync_act_high,
    input  logic             vsync_act_high,
    input  logic             cfg_wr_en,
    input  logic [1:0]       cfg_wr_addr,
    input  logic [CNT_W-1:0] cfg_wr_data,
    output logic             de_out
);

    logic [NUM_AXIS-1:0] sync_raw;
    logic [NUM_AXIS-1:0] sync_pol;
    logic [NUM_AXIS-1:0] sync_level;
    logic [NUM_AXIS-1:0] sync_start;
    logic [NUM_AXIS-1:0] axis_inside;
    logic [NUM_AXIS-1:0] axis_inc;

    logic [NUM_AXIS-1:0][CNT_W-1:0] axis_cnt;
    logic [NUM_AXIS-1:0][CNT_W-1:0] axis_first;
    logic [NUM_AXIS-1:0][CNT_W-1:0] axis_len;
    logic [NUM_CFG-1:0][CNT_W-1:0]  cfg_live;

    logic             h_start;
    logic             v_start;
    logic             vs_lvl;
    logic [CNT_W-1:0] pix_cnt;
    logic [CNT_W-1:0] line_cnt;

    assign sync_raw = {vsync_in, hsync_in};
    assign sync_pol = {vsync_act_high, hsync_act_high};

    assign h_start = sync_start[AXIS_H];
    assign v_start = sync_start[AXIS_V];
    assign vs_lvl  = sync_level[AXIS_V];

    // pixel counter steps every clock, line counter on each line edge
    assign axis_inc[AXIS_H] = 1'b1;
    assign axis_inc[AXIS_V] = h_start;

    assign axis_first[AXIS_H] = cfg_live[CFG_PIX_START];
    assign axis_len[AXIS_H]   = cfg_live[CFG_PIX_LEN];
    assign axis_first[AXIS_V] = cfg_live[CFG_LINE_START];
    assign axis_len[AXIS_V]   = cfg_live[CFG_LINE_LEN];

    assign pix_cnt  = axis_cnt[AXIS_H];
    assign line_cnt = axis_cnt[AXIS_V];

    for (genvar a = 0; a < NUM_AXIS; a++) begin : g_axis
        degen_sync_edge #(
            .STAGES (SYNC_STAGES)
        ) sync_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw_in   (sync_raw[a]),
            .act_high (sync_pol[a]),
            .level_o  (sync_level[a]),
            .start_o  (sync_start[a])
        );

        degen_sat_counter #(
            .W (CNT_W)
        ) cnt_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (sync_start[a]),
            .inc     (axis_inc[a]),
            .count_o (axis_cnt[a])
        );

        degen_window #(
            .W (CNT_W)
        ) win_i (
            .count    (axis_cnt[a]),
            .first    (axis_first[a]),
            .len      (axis_len[a]),
            .inside_o (axis_inside[a])
        );
    end

    degen_cfg_bank #(
        .W          (CNT_W),
        .DEF_HSTART (DEF_PIX_START),
        .DEF_HLEN   (DEF_PIX_LEN),
        .DEF_VSTART (DEF_LINE_START),
        .DEF_VLEN   (DEF_LINE_LEN)
    ) cfg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_addr (cfg_wr_addr),
        .wr_data (cfg_wr_data),
        .commit  (v_start),
        .live_o  (cfg_live)
    );

    typedef struct packed {
        logic de;
    } out_state_t;

    out_state_t o_d, o_q;

    always_comb begin
        o_d    = o_q;
        o_d.de = axis_inside[AXIS_H] & axis_inside[AXIS_V] & ~vs_lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q.de <= 1'b0;
        end else begin
            o_q <= o_d;
        end
    end

    assign de_out = o_q.de;

endmodule

// File: rtl/degen_checker.sv
module degen_checker #(
    parameter int unsigned W = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               h_start,
    input logic               v_start,
    input logic               vs_lvl,
    input logic [W-1:0]       pix_cnt,
    input logic [W-1:0]       line_cnt,
    input logic [3:0][W-1:0]  cfg_live,
    input logic               de_out
);

    localparam logic [W-1:0] CMAX = '1;

    // R5: asserted vertical sync blanks the next output cycle
    assert_vsync_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vs_lvl |=> !de_out);

    // R2: a line edge restarts the pixel count
    assert_pix_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        h_start |=> (pix_cnt == '0));

    // R3: pixel count steps by exactly one between line edges
    assert_pix_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!h_start && (pix_cnt != CMAX)) |=> (pix_cnt == $past(pix_cnt) + W'(1)));

    // R9: pixel count holds at its ceiling
    assert_pix_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!h_start && (pix_cnt == CMAX)) |=> (pix_cnt == CMAX));

    // R4: a frame edge restarts the line count
    assert_line_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        v_start |=> (line_cnt == '0));

    // R4: line count moves only on sync edges
    assert_line_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!v_start && !h_start) |=> $stable(line_cnt));

    // R9: line count holds at its ceiling
    assert_line_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!v_start && (line_cnt == CMAX)) |=> (line_cnt == CMAX));

    // R8: live window changes only on a frame edge
    assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !v_start |=> $stable(cfg_live));

endmodule

bind de_window_gen degen_checker #(
    .W (CNT_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .h_start  (h_start),
    .v_start  (v_start),
    .vs_lvl   (vs_lvl),
    .pix_cnt  (pix_cnt),
    .line_cnt (line_cnt),
    .cfg_live (cfg_live),
    .de_out   (de_out)
);

// File: tb/de_window_gen_tb_top.sv
`timescale 1ns/1ps
module de_window_gen_tb_top;

    localparam int CW     = 12;
    localparam int HS_W   = 3;   // horizontal sync width in clocks
    localparam int VS_L   = 2;   // vertical sync width in lines
    localparam int HT     = 40;  // short line length
    localparam int VT     = 12;  // short frame height
    localparam int NV     = 6;

    // columns: h polarity, v polarity, h start, h length, v start, v length
    localparam int VEC [NV][6] = '{
        '{1, 1,  5, 20, 2,  6},
        '{0, 1,  0,  1, 1, 10},
        '{1, 0, 10, 26, 3,  4},
        '{0, 0,  7,  0, 2,  5},
        '{1, 1,  3, 30, 0,  5},
        '{1, 1, 12, 24, 8,  3}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hsync_in = 1'b0;
    logic          vsync_in = 1'b0;
    logic          hpol = 1'b1;
    logic          vpol = 1'b1;
    logic          cfg_wr_en = 1'b0;
    logic [1:0]    cfg_wr_addr = 2'd0;
    logic [CW-1:0] cfg_wr_data = '0;
    logic          de_out;

    int n_checks = 0;
    int n_fail   = 0;
    string tag_sfx = "";

    always #2 clk = ~clk;

    de_window_gen dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .hsync_in       (hsync_in),
        .vsync_in       (vsync_in),
        .hsync_act_high (hpol),
        .vsync_act_high (vpol),
        .cfg_wr_en      (cfg_wr_en),
        .cfg_wr_addr    (cfg_wr_addr),
        .cfg_wr_data    (cfg_wr_data),
        .de_out         (de_out)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            hsync_in  = ~hpol;
            vsync_in  = ~vpol;
            cfg_wr_en = 1'b0;
        end
    endtask

    // R7: address 0 h start, 1 h length, 2 v start, 3 v length
    task automatic wr_cfg(input int a, input int v);
        @(negedge clk);
        cfg_wr_en   = 1'b1;
        cfg_wr_addr = 2'(a);
        cfg_wr_data = CW'(v);
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic load_cfg(input int ps, input int pd, input int ls, input int ld);
        wr_cfg(0, ps);
        wr_cfg(1, pd);
        wr_cfg(2, ls);
        wr_cfg(3, ld);
    endtask

    task automatic run_line(input int i, input int ht, input bit vs,
                            input int ps, input int pd, input int ls, input int ld,
                            input bit do_wr, input int nv [4]);
        int cnt;
        int first;
        bit act_line;
        int exp_cnt;
        string req;
        cnt   = 0;
        first = 0;
        for (int k = 1; k <= ht; k++) begin
            @(negedge clk);
            hsync_in = (k <= HS_W) ? hpol : ~hpol;
            vsync_in = vs ? vpol : ~vpol;
            if (do_wr && k <= 4) begin
                cfg_wr_en   = 1'b1;
                cfg_wr_addr = 2'(k - 1);
                cfg_wr_data = CW'(nv[k-1]);
            end else begin
                cfg_wr_en = 1'b0;
            end
            @(posedge clk);
            #1;
            if (de_out) begin
                cnt++;
                if (first == 0) first = k;
            end
        end
        act_line = (i >= VS_L) && (i > ls) && (i <= ls + ld);
        exp_cnt  = act_line ? pd : 0;
        if (i < VS_L)        req = "R5";
        else if (!act_line)  req = "R4";
        else if (pd == 0)    req = "R10";
        else                 req = "R3";
        check(cnt == exp_cnt, {req, tag_sfx}, $sformatf("line %0d DE cycles", i),
              cnt, exp_cnt);
        if (exp_cnt > 0)
            check(first == ps + 5, {"R2/R7", tag_sfx},
                  $sformatf("line %0d first DE edge", i), first, ps + 5);
    endtask

    task automatic run_frame(input int ht, input int nl,
                             input int ps, input int pd, input int ls, input int ld,
                             input int wr_line, input int nv [4]);
        for (int i = 0; i < nl; i++)
            run_line(i, ht, i < VS_L, ps, pd, ls, ld, i == wr_line, nv);
    endtask

    initial begin : watchdog
        #(150000 * 4);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
        $finish;
    end

    initial begin : main
        int none [4];
        int nb [4];
        int dcnt;
        none = '{0, 0, 0, 0};
        nb   = '{2, 8, 4, 3};

        hsync_in = 1'b0;
        vsync_in = 1'b0;
        repeat (5) @(negedge clk);
        #1;
        check(de_out == 1'b0, "R1", "DE during reset", int'(de_out), 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(6);
        check(de_out == 1'b0, "R1", "DE after reset", int'(de_out), 0);

        // R1: default window, only line 27 of 0..27 reaches the vertical window
        tag_sfx = "/R1";
        run_frame(700, 28, 148, 512, 26, 768, -1, none);
        tag_sfx = "";

        // table of modes walked by one loop
        for (int v = 0; v < NV; v++) begin
            hpol = VEC[v][0][0];
            vpol = VEC[v][1][0];
            tag_sfx = (hpol && vpol) ? "" : "/R6";
            idle(6);
            load_cfg(VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5]);
            run_frame(HT, VT, VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5], -1, none);
        end
        tag_sfx = "";
        hpol = 1'b1;
        vpol = 1'b1;
        idle(6);

        // R8: mid-frame writes wait for the next vertical sync
        load_cfg(5, 20, 2, 6);
        run_frame(HT, VT, 5, 20, 2, 6, -1, none);
        tag_sfx = "/R8";
        run_frame(HT, VT, 5, 20, 2, 6, 5, nb);
        run_frame(HT, VT, 2, 8, 4, 3, -1, none);
        tag_sfx = "";

        // R9: no horizontal sync for longer than the counter range
        run_frame(HT, 6, 2, 8, 4, 3, -1, none);
        dcnt = 0;
        for (int k = 0; k < 4300; k++) begin
            @(negedge clk);
            hsync_in = ~hpol;
            vsync_in = ~vpol;
            @(posedge clk);
            #1;
            if (de_out) dcnt++;
        end
        check(dcnt == 0, "R9", "DE cycles with missing hsync", dcnt, 0);
        tag_sfx = "/R9";
        run_frame(HT, VT, 2, 8, 4, 3, -1, none);
        tag_sfx = "";

        $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
        $finish;
    end

endmodule